// File: doc/BRIEF.md
# Tri-State Clock Phase Detector

This block steers an external voltage-controlled crystal oscillator into phase lock with a reference clock. It is needed because the transmit-side elastic store it serves has no slip detection of its own: if the variable clock drifts away from the reference, data is silently corrupted. Two asynchronous clock inputs are brought into one fast system clock domain through multi-flop synchronisers. Their rising edges are counted down to a common low comparison rate; the defaults divide a 2.048 MHz input by 256 and a 1.544 MHz input by 193, so that both reach 8 kHz. A configuration input chooses which of the two inputs is the reference and which is the variable clock.

A small state machine compares the divided edges. When the divided reference edge comes first and the divided variable edge has not followed within a programmable window of system-clock cycles, the error output is driven high until the variable edge arrives. When the variable edge comes first, the output is driven low until the reference edge arrives. When the two edges fall within the window of each other, the output stays undriven and a lock flag is raised. The three-state error pin is modelled as a drive-enable and a drive-level pair; the RC filter and the oscillator sit outside the block.

The states are: `PS_IDLE` (waiting for a divided edge), `PS_REF_LEAD` (reference seen, window open), `PS_VAR_LEAD` (variable seen, window open), `PS_PUSH_UP` (driving high) and `PS_PULL_DN` (driving low). Transitions: IDLE to IDLE with lock on coincident edges; IDLE to REF_LEAD or VAR_LEAD on a single edge; IDLE straight to PUSH_UP or PULL_DN on a single edge when the window is zero; REF_LEAD or VAR_LEAD to IDLE with lock when the other edge arrives in the window; REF_LEAD to PUSH_UP and VAR_LEAD to PULL_DN when the window runs out; PUSH_UP to IDLE on the variable edge; PULL_DN to IDLE on the reference edge.

Top module: `clk_phase_steer`

## Requirements
- R1: After reset the drive-enable `err_oe`, the drive-level `err_level` and the `locked` flag are all 0.
- R2: Each input passes through a synchroniser of `SYNC_STAGES` flops; every rising edge is counted, and one divided edge is produced per `DIV_A` rising edges of `clk_a_in` and per `DIV_B` rising edges of `clk_b_in` (defaults 256 and 193; a ratio of 1 passes every edge).
- R3: With `swap_ref` = 0, `clk_a_in` is the reference and `clk_b_in` the variable clock; with `swap_ref` = 1 the roles are exchanged.
- R4: When the divided reference edge comes first and no divided variable edge follows within `lock_win` system cycles, the block drives `err_oe` = 1, `err_level` = 1 until the divided variable edge arrives, then releases (`err_oe` = 0).
- R5: When the divided variable edge comes first and no divided reference edge follows within `lock_win` system cycles, the block drives `err_oe` = 1, `err_level` = 0 until the divided reference edge arrives, then releases.
- R6: When the two divided edges are separated by at most `lock_win` system cycles (coincident edges included), no drive occurs and `locked` becomes 1.
- R7: `locked` keeps its value until a drive starts, and clears in the cycle the drive starts.
- R8: Whenever `err_oe` is 0, `err_level` is 0.
- R9: Further edges of the leading clock during a drive do not end it; the drive lasts until the lagging clock's divided edge arrives.
- R10: With `lock_win` = 0 only coincident divided edges count as locked; a separation of one cycle already produces a drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples both inputs |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| clk_a_in | input | 1 | First monitored clock (reference when `swap_ref` = 0) |
| clk_b_in | input | 1 | Second monitored clock (variable when `swap_ref` = 0) |
| swap_ref | input | 1 | 1 makes `clk_b_in` the reference and `clk_a_in` the variable clock |
| lock_win | input | WIN_W | Lock window in system-clock cycles |
| err_oe | output | 1 | Drive-enable of the three-state error pin; 0 means high impedance |
| err_level | output | 1 | Level driven when `err_oe` is 1: 1 raises, 0 lowers the oscillator |
| locked | output | 1 | Set when the last edge pair fell within the window |

## Verification
The main instance is built with both divide ratios set to 1, so every rising edge the bench places on an input becomes a divided edge and the separation between the two inputs maps cycle for cycle onto the window counter; this brings the window boundary (separation equal to and one above `lock_win`), a zero window and both role settings within a short run. A second instance uses ratios 4 and 3, so that twelve common input edges give a known pattern of unequal divided edges, which exercises the counting path of the dividers and repeated low drives without thousands of input edges.

// File: rtl/phase_steer_pkg.sv
package phase_steer_pkg;

    typedef enum logic [2:0] {
        PS_IDLE     = 3'd0,
        PS_REF_LEAD = 3'd1,
        PS_VAR_LEAD = 3'd2,
        PS_PUSH_UP  = 3'd3,
        PS_PULL_DN  = 3'd4
    } ps_state_t;

endpackage

// File: rtl/ps_edge_sync.sv
module ps_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], async_in};
        end
    end

    // Last synchroniser flop high, history flop low: one rising edge.
    assign rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

    // R2: an edge is reported for one cycle only
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/ps_edge_divider.sv
module ps_edge_divider #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_in,
    output logic pulse
);

    generate
        if (DIV == 1) begin : g_pass
            assign pulse = edge_in;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (edge_in) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            assign pulse = edge_in && (cnt_q == LAST);

            // R2: divided edges never come back to back when DIV > 1
            p_div_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
                pulse |=> !pulse);
        end
    endgenerate

endmodule

// File: rtl/ps_phase_fsm.sv
module ps_phase_fsm
    import phase_steer_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             var_pulse,
    input  logic [WIN_W-1:0] lock_win,
    output logic             err_oe,
    output logic             err_level,
    output logic             locked
);

    ps_state_t        state_q, state_d;
    logic [WIN_W-1:0] gap_q;
    logic             gap_load;
    logic             gap_step;
    logic             lock_hit;
    logic             win_zero;

    assign win_zero = (lock_win == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        gap_load = 1'b0;
        gap_step = 1'b0;
        lock_hit = 1'b0;
        unique case (state_q)
            PS_IDLE: begin
                if (ref_pulse && var_pulse) begin
                    lock_hit = 1'b1;
                end else if (ref_pulse) begin
                    gap_load = 1'b1;
                    state_d  = win_zero ? PS_PUSH_UP : PS_REF_LEAD;
                end else if (var_pulse) begin
                    gap_load = 1'b1;
                    state_d  = win_zero ? PS_PULL_DN : PS_VAR_LEAD;
                end
            end
            PS_REF_LEAD: begin
                if (var_pulse) begin
                    lock_hit = 1'b1;
                    state_d  = PS_IDLE;
                end else if (gap_q >= lock_win) begin
                    state_d = PS_PUSH_UP;
                end else begin
                    gap_step = 1'b1;
                end
            end
            PS_VAR_LEAD: begin
                if (ref_pulse) begin
                    lock_hit = 1'b1;
                    state_d  = PS_IDLE;
                end else if (gap_q >= lock_win) begin
                    state_d = PS_PULL_DN;
                end else begin
                    gap_step = 1'b1;
                end
            end
            PS_PUSH_UP: begin
                if (var_pulse) begin
                    state_d = PS_IDLE;
                end
            end
            PS_PULL_DN: begin
                if (ref_pulse) begin
                    state_d = PS_IDLE;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    // Window counter and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            locked <= 1'b0;
        end else begin
            if (gap_load) begin
                gap_q <= WIN_W'(1);
            end else if (gap_step) begin
                gap_q <= gap_q + 1'b1;
            end
            if (lock_hit) begin
                locked <= 1'b1;
            end else if ((state_d == PS_PUSH_UP || state_d == PS_PULL_DN) &&
                         state_d != state_q) begin
                locked <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        err_oe    = 1'b0;
        err_level = 1'b0;
        unique case (state_q)
            PS_PUSH_UP: begin
                err_oe    = 1'b1;
                err_level = 1'b1;
            end
            PS_PULL_DN: begin
                err_oe    = 1'b1;
                err_level = 1'b0;
            end
            default: begin
                err_oe    = 1'b0;
                err_level = 1'b0;
            end
        endcase
    end

    // R6, R7: a set lock flag never coexists with a drive
    p_lock_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !err_oe);

    // R8: level is low while the pin is released
    p_hiz_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !err_oe |-> !err_level);

    // R4: the variable edge ends a high drive
    p_up_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PUSH_UP && var_pulse) |=> !err_oe);

    // R5: the reference edge ends a low drive
    p_dn_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PULL_DN && ref_pulse) |=> !err_oe);

    // R9: a high drive holds until the variable edge
    p_up_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PUSH_UP && !var_pulse) |=> (err_oe && err_level));

    // R6: coincident divided edges lock
    p_coincide_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && ref_pulse && var_pulse) |=> locked);

endmodule

// File: rtl/clk_phase_steer.sv
module clk_phase_steer #(
    parameter int DIV_A       = 256,
    parameter int DIV_B       = 193,
    parameter int WIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_a_in,
    input  logic             clk_b_in,
    input  logic             swap_ref,
    input  logic [WIN_W-1:0] lock_win,
    output logic             err_oe,
    output logic             err_level,
    output logic             locked
);

    logic rise_a, rise_b;
    logic div_a, div_b;
    logic ref_pulse, var_pulse;

    ps_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (clk_a_in),
        .rise     (rise_a)
    );

    ps_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (clk_b_in),
        .rise     (rise_b)
    );

    ps_edge_divider #(.DIV(DIV_A)) u_div_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_in (rise_a),
        .pulse   (div_a)
    );

    ps_edge_divider #(.DIV(DIV_B)) u_div_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_in (rise_b),
        .pulse   (div_b)
    );

    // R3: role selection
    assign ref_pulse = swap_ref ? div_b : div_a;
    assign var_pulse = swap_ref ? div_a : div_b;

    ps_phase_fsm #(.WIN_W(WIN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .var_pulse (var_pulse),
        .lock_win  (lock_win),
        .err_oe    (err_oe),
        .err_level (err_level),
        .locked    (locked)
    );

endmodule

// File: tb/sim_clk_phase_steer.sv
module sim_clk_phase_steer;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    typedef struct packed {
        logic       a_first;
        logic       swap;
        logic [7:0] win;
        logic [7:0] sep;
        logic       exp_up;
        logic       exp_dn;
        logic       exp_lock;
    } vec_t;

    // a_first, swap, win, sep, exp_up, exp_dn, exp_lock
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'd3, 8'd2, 1'b0, 1'b0, 1'b1},  // R6 inside window
        '{1'b1, 1'b0, 8'd3, 8'd3, 1'b0, 1'b0, 1'b1},  // R6 at boundary
        '{1'b1, 1'b0, 8'd3, 8'd4, 1'b1, 1'b0, 1'b0},  // R4 reference leads
        '{1'b0, 1'b0, 8'd3, 8'd6, 1'b0, 1'b1, 1'b0},  // R5 variable leads
        '{1'b1, 1'b1, 8'd3, 8'd6, 1'b0, 1'b1, 1'b0},  // R3 a is variable, leads
        '{1'b0, 1'b1, 8'd3, 8'd6, 1'b1, 1'b0, 1'b0},  // R3 b is reference, leads
        '{1'b1, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1},  // R10 coincident
        '{1'b1, 1'b0, 8'd0, 8'd1, 1'b1, 1'b0, 1'b0},  // R10 one cycle apart
        '{1'b0, 1'b1, 8'd5, 8'd5, 1'b0, 1'b0, 1'b1}   // R6 boundary, swapped
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_in = 1'b0, b_in = 1'b0, swap = 1'b0;
    logic [7:0] win = 8'd0;
    logic       oe0, lvl0, lock0;
    logic       a1_in = 1'b0, b1_in = 1'b0;
    logic       oe1, lvl1, lock1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit saw_up = 1'b0, saw_dn = 1'b0, saw_hiz_high = 1'b0;
    int dn_starts = 0, up_starts = 0;
    logic prev_dn1 = 1'b0, prev_up1 = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clk_phase_steer #(.DIV_A(1), .DIV_B(1), .WIN_W(8)) u0 (
        .clk (clk), .rst_n (rst_n), .clk_a_in (a_in), .clk_b_in (b_in),
        .swap_ref (swap), .lock_win (win),
        .err_oe (oe0), .err_level (lvl0), .locked (lock0)
    );

    clk_phase_steer #(.DIV_A(4), .DIV_B(3), .WIN_W(8)) u1 (
        .clk (clk), .rst_n (rst_n), .clk_a_in (a1_in), .clk_b_in (b1_in),
        .swap_ref (1'b0), .lock_win (8'd2),
        .err_oe (oe1), .err_level (lvl1), .locked (lock1)
    );

    always @(negedge clk) begin
        if (oe0 && lvl0)   saw_up = 1'b1;
        if (oe0 && !lvl0)  saw_dn = 1'b1;
        if (!oe0 && lvl0)  saw_hiz_high = 1'b1;
        if (oe1 && !lvl1 && !prev_dn1) dn_starts++;
        if (oe1 && lvl1 && !prev_up1)  up_starts++;
        prev_dn1 = oe1 && !lvl1;
        prev_up1 = oe1 && lvl1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic run_vec(input vec_t v);
        swap = v.swap;
        win  = v.win;
        step(2);
        saw_up = 1'b0;
        saw_dn = 1'b0;
        if (v.sep == 0) begin
            a_in = 1'b1;
            b_in = 1'b1;
        end else begin
            if (v.a_first) a_in = 1'b1; else b_in = 1'b1;
            step(int'(v.sep));
            if (v.a_first) b_in = 1'b1; else a_in = 1'b1;
        end
        step(int'(v.sep) + int'(v.win) + 12);
        check("R4 high drive seen", 32'(saw_up), 32'(v.exp_up));
        check("R5 low drive seen", 32'(saw_dn), 32'(v.exp_dn));
        check("R6/R7 lock flag", 32'(lock0), 32'(v.exp_lock));
        check("R8 released after pair", {oe0, lvl0}, 32'd0);
        a_in = 1'b0;
        b_in = 1'b0;
        step(6);
    endtask

    initial begin
        step(5);
        check("R1 oe in reset", 32'(oe0), 32'd0);
        rst_n = 1'b1;
        step(3);
        check("R1 oe after reset", 32'(oe0), 32'd0);
        check("R1 level after reset", 32'(lvl0), 32'd0);
        check("R1 lock after reset", 32'(lock0), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
        end

        // R9: repeated reference edges keep the high drive
        swap = 1'b0;
        win  = 8'd2;
        step(2);
        a_in = 1'b1;
        step(10);
        check("R9 first drive high", {oe0, lvl0}, 32'd3);
        a_in = 1'b0;
        step(4);
        a_in = 1'b1;
        step(10);
        check("R9 drive held over second ref edge", {oe0, lvl0}, 32'd3);
        b_in = 1'b1;
        step(8);
        check("R4 release on variable edge", 32'(oe0), 32'd0);
        check("R7 lock cleared by drive", 32'(lock0), 32'd0);
        a_in = 1'b0;
        b_in = 1'b0;
        step(6);
        check("R8 no high level while released", 32'(saw_hiz_high), 32'd0);

        // R2: dividers 4 and 3 on twelve common edges
        for (int e = 1; e <= 12; e++) begin
            a1_in = 1'b1;
            b1_in = 1'b1;
            step(6);
            a1_in = 1'b0;
            b1_in = 1'b0;
            step(6);
        end
        step(10);
        check("R2 low drive count from divided edges", 32'(dn_starts), 32'd3);
        check("R2 no high drive from divided edges", 32'(up_starts), 32'd0);
        check("R2 released after common edge", 32'(oe1), 32'd0);
        check("R2 lock flag after drives", 32'(lock1), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule